// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit carries out one vector-length configuration operation per issue cycle against a 64-bit vector state word that it holds itself. The operation's fields arrive already decoded: an immediate that selects a new maximum length, three mode flags (vertical-first, set-length and set-maximum), a destination register index, a record bit and the value read from the source register. From these the unit computes a new maximum length and a new current length, clears both element-step counters, and updates the mode bit.

It returns three things: a zero-extended copy of the new length for the register file, a 4-bit condition field when the record bit is set, and a step request that is raised in place of all of the above when the flags select the element-stepping path. That stepping path belongs to another block.

All results are registered. A single-cycle valid strobe marks the cycle in which they apply. The state word is visible at all times.

Top module: `svl_unit`

## Requirements
- R1: Reset is synchronous and active-low. A clock edge that samples `rst_ni` low clears the state word and every output to zero, whatever `issue_i` holds.
- R2: Results take one cycle. `valid_o` is high in exactly the cycle after a cycle with `issue_i` high, and low otherwise.
- R3: An issue with `vf_i`=1, `vs_i`=0 and `ms_i`=0 takes the step path. In the next cycle `step_req_o` is high, `rd_we_o` and `cr_we_o` are low, and the state word is unchanged. Every other issue takes the set path with `step_req_o` low.
- R4: On the set path with `ms_i`=1, the new maximum length is `imm_i`+1, saturating at 127. With `ms_i`=0 the maximum length is kept.
- R5: On the set path with `vs_i`=1, the new length is `src_i` clamped to the new maximum length by a 64-bit unsigned comparison. With `vs_i`=0 it is the old length clamped to the new maximum. For example, with a maximum of 5, a source of 4 gives 4 and a source of 0 gives 0.
- R6: State word layout, in MSB-0 numbering:
  - bits 0 to 6 (LSB-0 63:57) hold the maximum length;
  - bits 7 to 13 (LSB-0 56:50) hold the current length;
  - bits 14 to 20 hold the source step and bits 21 to 27 the destination step, and the set path clears both;
  - bit 63 (LSB-0 bit 0) is the mode bit;
  - all other bits are unchanged.
- R7: On the set path, if `vs_i` or `ms_i` is 1, the mode bit takes `vf_i`. Otherwise the mode bit keeps its value.
- R8: On the set path, `rd_data_o` is the new length zero-extended to 64 bits and `rd_idx_o` echoes `rd_idx_i`. `rd_we_o` is high only when `rd_idx_i` is nonzero.
- R9: On the set path with `rc_i`=1, `cr_we_o` is high and `cr_o` is {LT,GT,EQ,SO} in bits 3 to 0. It reads 4'b0010 when the returned length is zero and 4'b0100 otherwise. It is derived from the returned length even when the register write is suppressed. With `rc_i`=0, `cr_we_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | An operation is presented this cycle |
| imm_i | input | 7 | Immediate; requested maximum length minus one |
| vf_i | input | 1 | Vertical-first flag |
| vs_i | input | 1 | Set the length from the source value |
| ms_i | input | 1 | Set the maximum length from the immediate |
| rd_idx_i | input | 5 | Destination register index |
| rc_i | input | 1 | Record bit; requests the condition field |
| src_i | input | 64 | Source register value |
| valid_o | output | 1 | Results below apply this cycle |
| state_o | output | 64 | Vector state word |
| rd_we_o | output | 1 | Destination write enable |
| rd_idx_o | output | 5 | Destination register index |
| rd_data_o | output | 64 | Zero-extended new length |
| cr_we_o | output | 1 | Condition field write enable |
| cr_o | output | 4 | Condition field {LT,GT,EQ,SO} |
| step_req_o | output | 1 | Hand-off to the element-stepping path |

## Verification
Every result of an issue is due one clock edge later: the state word, the valid strobe, the register write, the condition field and the step request. The bench therefore applies each operation just after a rising edge, advances its reference model by one operation, and compares all outputs one time unit after the next rising edge. The compared outputs include the full state word, so an unchanged state or a cleared step field is checked directly. The data, index and condition values are compared only in cycles whose enable the model expects to be high.

// File: rtl/svl_pkg.sv
// Package: shared types of the vector length setting unit.
// Assumes: nothing beyond the standard types.
package svl_pkg;

    // Which path an issued operation takes.
    typedef enum logic [1:0] {
        PATH_IDLE = 2'd0,
        PATH_SET  = 2'd1,
        PATH_STEP = 2'd2
    } svl_path_e;

    // Condition field, most significant flag first.
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } svl_cr_t;

endpackage

// File: rtl/svl_decode.sv
// Module: svl_decode
// Chooses between the idle, set-length and step paths from the issue strobe and mode flags.
// Assumes: flags are stable while issue_i is high; purely combinational.
module svl_decode
    import svl_pkg::*;
(
    input  logic      issue_i,
    input  logic      vf_i,
    input  logic      vs_i,
    input  logic      ms_i,
    output svl_path_e path_o
);

    // Step path only for vertical-first with neither set flag.
    always_comb begin
        if (!issue_i)
            path_o = PATH_IDLE;
        else if (vf_i && !vs_i && !ms_i)
            path_o = PATH_STEP;
        else
            path_o = PATH_SET;
    end

endmodule

// File: rtl/svl_length_calc.sv
// Module: svl_length_calc
// Computes the new maximum length and current length for the set path.
// Assumes: lengths are LW bits wide; the source value is compared unsigned at full width.
module svl_length_calc #(
    parameter int XLEN = 64,
    parameter int LW   = 7
) (
    input  logic [LW-1:0]   old_max_i,
    input  logic [LW-1:0]   old_len_i,
    input  logic [LW-1:0]   imm_i,
    input  logic            ms_i,
    input  logic            vs_i,
    input  logic [XLEN-1:0] src_i,
    output logic [LW-1:0]   new_max_o,
    output logic [LW-1:0]   new_len_o
);

    localparam logic [LW-1:0] LEN_ALL_ONES = {LW{1'b1}};

    logic [XLEN-1:0] max_wide;

    // New maximum: immediate plus one with saturation, or the kept value.
    always_comb begin
        if (!ms_i)
            new_max_o = old_max_i;
        else if (imm_i == LEN_ALL_ONES)
            new_max_o = LEN_ALL_ONES;
        else
            new_max_o = imm_i + LW'(1);
    end

    assign max_wide = {{(XLEN-LW){1'b0}}, new_max_o};

    // New length: source or old length, clamped to the new maximum.
    always_comb begin
        if (vs_i)
            new_len_o = (src_i > max_wide) ? new_max_o : src_i[LW-1:0];
        else
            new_len_o = (old_len_i > new_max_o) ? new_max_o : old_len_i;
    end

endmodule

// File: rtl/svl_cond_gen.sv
// Module: svl_cond_gen
// Derives the condition field from the value returned to the destination register.
// Assumes: the value is zero-extended, so it is never negative; no overflow is tracked.
module svl_cond_gen
    import svl_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] result_i,
    output svl_cr_t         cr_o
);

    // EQ for a zero result, GT for any other; LT and SO stay clear.
    always_comb begin
        cr_o.lt = 1'b0;
        cr_o.eq = (result_i == '0);
        cr_o.gt = (result_i != '0);
        cr_o.so = 1'b0;
    end

endmodule

// File: rtl/svl_unit.sv
// Module: svl_unit (top)
// Executes a vector-length configuration operation on an internal state word.
// It returns a registered length result, an optional condition field, or a step request.
// Assumes: one operation per cycle at most; the register file and the stepping path are external.
module svl_unit
    import svl_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int LW     = 7,
    parameter int RIDX_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              issue_i,
    input  logic [LW-1:0]     imm_i,
    input  logic              vf_i,
    input  logic              vs_i,
    input  logic              ms_i,
    input  logic [RIDX_W-1:0] rd_idx_i,
    input  logic              rc_i,
    input  logic [XLEN-1:0]   src_i,
    output logic              valid_o,
    output logic [XLEN-1:0]   state_o,
    output logic              rd_we_o,
    output logic [RIDX_W-1:0] rd_idx_o,
    output logic [XLEN-1:0]   rd_data_o,
    output logic              cr_we_o,
    output logic [3:0]        cr_o,
    output logic              step_req_o
);

    // Field placement: MSB-0 fields counted down from the top bit.
    localparam int MAX_LSB   = XLEN - LW;
    localparam int LEN_LSB   = XLEN - 2*LW;
    localparam int SSTEP_LSB = XLEN - 3*LW;
    localparam int DSTEP_LSB = XLEN - 4*LW;
    localparam int MODE_BIT  = 0;

    logic [XLEN-1:0]   state_q, state_d;
    logic [LW-1:0]     new_max, new_len;
    logic [XLEN-1:0]   result;
    svl_path_e         path;
    svl_cr_t           cr_s, cr_q;
    logic              valid_q, step_q, rd_we_q, cr_we_q;
    logic [RIDX_W-1:0] rd_idx_q;
    logic [XLEN-1:0]   rd_data_q;

    svl_decode dec_i (
        .issue_i (issue_i),
        .vf_i    (vf_i),
        .vs_i    (vs_i),
        .ms_i    (ms_i),
        .path_o  (path)
    );

    svl_length_calc #(.XLEN(XLEN), .LW(LW)) calc_i (
        .old_max_i (state_q[MAX_LSB +: LW]),
        .old_len_i (state_q[LEN_LSB +: LW]),
        .imm_i     (imm_i),
        .ms_i      (ms_i),
        .vs_i      (vs_i),
        .src_i     (src_i),
        .new_max_o (new_max),
        .new_len_o (new_len)
    );

    assign result = {{(XLEN-LW){1'b0}}, new_len};

    svl_cond_gen #(.XLEN(XLEN)) cond_i (
        .result_i (result),
        .cr_o     (cr_s)
    );

    // Next state word: only the set path rewrites fields.
    always_comb begin
        state_d = state_q;
        if (path == PATH_SET) begin
            state_d[MAX_LSB +: LW]   = new_max;
            state_d[LEN_LSB +: LW]   = new_len;
            state_d[SSTEP_LSB +: LW] = '0;
            state_d[DSTEP_LSB +: LW] = '0;
            if (vs_i || ms_i)
                state_d[MODE_BIT] = vf_i;
        end
    end

    // Registers for the state word and all results.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q   <= '0;
            valid_q   <= 1'b0;
            step_q    <= 1'b0;
            rd_we_q   <= 1'b0;
            cr_we_q   <= 1'b0;
            rd_idx_q  <= '0;
            rd_data_q <= '0;
            cr_q      <= '0;
        end else begin
            state_q   <= state_d;
            valid_q   <= (path != PATH_IDLE);
            step_q    <= (path == PATH_STEP);
            rd_we_q   <= (path == PATH_SET) && (rd_idx_i != '0);
            cr_we_q   <= (path == PATH_SET) && rc_i;
            rd_idx_q  <= rd_idx_i;
            rd_data_q <= result;
            cr_q      <= cr_s;
        end
    end

    assign valid_o    = valid_q;
    assign state_o    = state_q;
    assign rd_we_o    = rd_we_q;
    assign rd_idx_o   = rd_idx_q;
    assign rd_data_o  = rd_data_q;
    assign cr_we_o    = cr_we_q;
    assign cr_o       = cr_q;
    assign step_req_o = step_q;

endmodule

// File: rtl/svl_unit_chk.sv
// Module: svl_unit_chk
// Temporal checks on the ports of svl_unit; attached by the bind below.
// Assumes: the same parameters as the bound instance.
module svl_unit_chk #(
    parameter int XLEN   = 64,
    parameter int LW     = 7,
    parameter int RIDX_W = 5
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              issue_i,
    input logic              valid_o,
    input logic [XLEN-1:0]   state_o,
    input logic              rd_we_o,
    input logic [RIDX_W-1:0] rd_idx_o,
    input logic [XLEN-1:0]   rd_data_o,
    input logic              cr_we_o,
    input logic [3:0]        cr_o,
    input logic              step_req_o
);

    localparam int MAX_LSB   = XLEN - LW;
    localparam int LEN_LSB   = XLEN - 2*LW;
    localparam int DSTEP_LSB = XLEN - 4*LW;

    // R2
    valid_follows_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_i |=> valid_o);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !issue_i |=> !valid_o);

    // R3
    step_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_req_o |-> (!rd_we_o && !cr_we_o && valid_o && state_o == $past(state_o)));

    // R5
    len_within_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o[LEN_LSB +: LW] <= state_o[MAX_LSB +: LW]);

    // R6
    steps_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o[DSTEP_LSB +: 2*LW] == '0);

    // R8
    write_needs_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_we_o |-> (valid_o && rd_idx_o != '0 && rd_data_o[XLEN-1:LW] == '0));

    // R9
    cond_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cr_we_o |-> (valid_o && !cr_o[3] && !cr_o[0] && $countones(cr_o[2:1]) == 1));

    // R9
    cond_matches_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cr_we_o && rd_we_o) |-> (cr_o[1] == (rd_data_o == '0)));

endmodule

bind svl_unit svl_unit_chk #(.XLEN(XLEN), .LW(LW), .RIDX_W(RIDX_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (issue_i),
    .valid_o    (valid_o),
    .state_o    (state_o),
    .rd_we_o    (rd_we_o),
    .rd_idx_o   (rd_idx_o),
    .rd_data_o  (rd_data_o),
    .cr_we_o    (cr_we_o),
    .cr_o       (cr_o),
    .step_req_o (step_req_o)
);

// File: tb/svl_unit_tb_top.sv
// Bench for svl_unit: a behavioural reference model advanced once per clock,
// with every output compared one time unit after each rising edge.
module svl_unit_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        issue_i = 1'b0;
    logic [6:0]  imm_i = '0;
    logic        vf_i = 1'b0, vs_i = 1'b0, ms_i = 1'b0, rc_i = 1'b0;
    logic [4:0]  rd_idx_i = '0;
    logic [63:0] src_i = '0;

    logic        valid_o, rd_we_o, cr_we_o, step_req_o;
    logic [63:0] state_o, rd_data_o;
    logic [4:0]  rd_idx_o;
    logic [3:0]  cr_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model state
    int unsigned m_max = 0, m_len = 0;
    bit          m_mode = 0;

    // Expected outputs after the coming edge
    bit          e_valid, e_rdwe, e_crwe, e_step;
    logic [63:0] e_state, e_rddata;
    logic [4:0]  e_rdidx;
    logic [3:0]  e_cr;

    always #2 clk_i = ~clk_i;

    svl_unit dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .issue_i(issue_i), .imm_i(imm_i),
        .vf_i(vf_i), .vs_i(vs_i), .ms_i(ms_i), .rd_idx_i(rd_idx_i), .rc_i(rc_i),
        .src_i(src_i), .valid_o(valid_o), .state_o(state_o), .rd_we_o(rd_we_o),
        .rd_idx_o(rd_idx_o), .rd_data_o(rd_data_o), .cr_we_o(cr_we_o), .cr_o(cr_o),
        .step_req_o(step_req_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus, advance the model, compare after the edge.
    task automatic cycle(input bit rstn, input bit iss, input logic [6:0] imm,
                         input bit vf, input bit vs, input bit ms,
                         input logic [4:0] rd, input bit rc, input logic [63:0] src);
        int unsigned nmax, nlen;
        rst_ni = rstn; issue_i = iss; imm_i = imm; vf_i = vf; vs_i = vs; ms_i = ms;
        rd_idx_i = rd; rc_i = rc; src_i = src;
        e_valid = 0; e_rdwe = 0; e_crwe = 0; e_step = 0; e_rddata = '0; e_rdidx = '0; e_cr = '0;
        if (!rstn) begin
            m_max = 0; m_len = 0; m_mode = 0;
        end else if (iss) begin
            e_valid = 1;
            if (vf && !vs && !ms) begin
                e_step = 1;
            end else begin
                nmax = ms ? ((imm == 7'd127) ? 127 : int'(imm) + 1) : m_max;
                if (vs) nlen = (src > 64'(nmax)) ? nmax : int'(src[6:0]);
                else    nlen = (m_len > nmax) ? nmax : m_len;
                m_max = nmax; m_len = nlen;
                if (vs || ms) m_mode = vf;
                e_rddata = 64'(nlen);
                e_rdidx  = rd;
                e_rdwe   = (rd != 0);
                e_crwe   = rc;
                e_cr     = (nlen == 0) ? 4'b0010 : 4'b0100;
            end
        end
        e_state = {7'(m_max), 7'(m_len), 49'd0, m_mode};
        @(posedge clk_i);
        #1;
        if (!rstn) begin
            chk("R1 reset state", state_o, 64'd0);
            chk("R1 reset outputs", {valid_o, rd_we_o, cr_we_o, step_req_o, cr_o}, '0);
        end else begin
            chk("R2 valid", valid_o, e_valid);
            chk("R6 R4 R5 R7 state", state_o, e_state);
            chk("R3 step", step_req_o, e_step);
            chk("R8 write enable", rd_we_o, e_rdwe);
            chk("R9 cond enable", cr_we_o, e_crwe);
            if (e_rdwe) begin
                chk("R8 data", rd_data_o, e_rddata);
                chk("R8 index", rd_idx_o, e_rdidx);
            end
            if (e_crwe) chk("R9 cond", cr_o, e_cr);
        end
    endtask

    initial begin
        logic [63:0] r;
        // R1: reset wins over an issue
        repeat (3) cycle(0, 1, 7'd9, 0, 1, 1, 5'd3, 1, 64'd7);
        // R4: maximum 5, length from old (0)
        cycle(1, 1, 7'd4, 0, 0, 1, 5'd0, 0, 64'd0);
        // R5 R9: source 4 under maximum 5 -> 4, GT
        cycle(1, 1, 7'd0, 0, 1, 0, 5'd5, 1, 64'd4);
        // R5 R9: source 0 -> 0, EQ
        cycle(1, 1, 7'd0, 0, 1, 0, 5'd5, 1, 64'd0);
        // R5: clamp, including a value negative if read as signed
        cycle(1, 1, 7'd0, 0, 1, 0, 5'd7, 1, 64'd1000);
        cycle(1, 1, 7'd0, 0, 1, 0, 5'd7, 1, 64'h8000_0000_0000_0003);
        // R8 R9: destination 0 suppresses write, condition still reported
        cycle(1, 1, 7'd0, 0, 1, 0, 5'd0, 1, 64'd3);
        // R2: idle cycle
        cycle(1, 0, 7'd0, 0, 0, 0, 5'd1, 1, 64'd0);
        // R3: step path leaves the state alone
        cycle(1, 1, 7'd20, 1, 0, 0, 5'd2, 1, 64'd9);
        // R4: saturation at 127, length kept
        cycle(1, 1, 7'd127, 0, 0, 1, 5'd1, 0, 64'd0);
        // R4 R5: shrink maximum to 2, old length 3 clamps
        cycle(1, 1, 7'd1, 0, 0, 1, 5'd1, 1, 64'd0);
        // R7: mode set, preserved with no set flags, then cleared
        cycle(1, 1, 7'd0, 1, 1, 0, 5'd1, 0, 64'd1);
        cycle(1, 1, 7'd0, 0, 0, 0, 5'd1, 0, 64'd0);
        cycle(1, 1, 7'd10, 0, 0, 1, 5'd1, 0, 64'd0);
        // Mixed stimulus from a fixed LFSR
        r = 64'hACE1_2345_6789_BEEF;
        for (int i = 0; i < 400; i++) begin
            r = {r[62:0], r[63] ^ r[62] ^ r[60] ^ r[59]};
            cycle(1, r[0] | r[1], r[14:8], r[2], r[3], r[4], r[19:15], r[5],
                  r[6] ? {57'd0, r[26:20]} : (r[7] ? 64'd0 : r));
        end
        // R1: reset in mid-run
        cycle(0, 1, 7'd3, 0, 1, 1, 5'd4, 1, 64'd2);
        cycle(1, 0, 7'd0, 0, 0, 0, 5'd0, 0, 64'd0);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule